// File: doc/BRIEF.md
# Flow-Through VLIW Packet Stage

This block is a single link in a linear chain of small packet processors. On every clock it accepts one bundle: eight 32-bit general registers, a 16-byte window onto the current packet, an 8-bit fragment index, a one-bit condition flag, an 8-bit instruction pointer and a valid bit. The instruction pointer selects one 64-bit instruction word from a local program store. That word holds four fixed slots: an ALU, a compare unit, a branch unit and a move unit. The four slots execute in parallel. Their results are not written back into this stage. They go into the output bundle, which is the next stage's input.

Every field that no slot writes leaves the stage unchanged. The stage has no handshake and never stalls, so a bundle always spends exactly one cycle in it. Slot scheduling is the compiler's job and the hardware checks no hazards. The program store is filled through a simple write port before traffic starts.

Top module: `vliw_flow_stage`

## Requirements
- R1: While rstN is low, every output is held at zero, including outValid.
- R2: outValid on each clock equals inValid of the previous clock. There is no stall or backpressure, so a valid bundle leaves exactly one cycle after it enters.
- R3: A bundle with inValid low executes nothing. The outputs outRegs, outWindow, outFrag, outIp and outFlag keep their previous values.
- R4: The executed word is program entry inIp modulo PROG_DEPTH. Slot 0 is bits [15:0], slot 1 is bits [31:16], slot 2 is bits [47:32] and slot 3 is bits [63:48]. Register i is inRegs[32i+31:32i], and window byte i is inWindow[8i+7:8i].
- R5: ALU slot (slot 0) fields are: op [15:13], rd [12:10], ra [9:7], rb [6:4]. The op codes are 1 add, 2 subtract (ra minus rb), 3 and, 4 or, 5 xor. Codes 0, 6 and 7 are no-ops. The result is written to rd modulo 2^32.
- R6: Compare slot (slot 1) fields are: op [15:13], ra [12:10], rb [9:7]. Op 1 sets outFlag to (ra == rb). Op 2 sets outFlag to unsigned (ra < rb). Any other op passes inFlag through.
- R7: Branch slot (slot 2) fields are: condition [15:14] and target [7:0]. The conditions are 1 always, 2 if inFlag is 1, 3 if inFlag is 0. When the branch is taken, outIp is the target. Otherwise outIp is inIp+1, wrapping from 255 to 0. The branch tests the incoming flag, not the one computed in the same word.
- R8: Move slot (slot 3) fields are: op [15:13], rd [12:10], imm [7:0], with offset = imm[3:0]. Op 1 loads window byte offset, zero-extended, into rd. Op 2 loads the 32-bit little-endian value of bytes offset..offset+3 into rd, with byte indices wrapping modulo 16.
- R9: Move op 3 sets outFrag to imm. Move op 4, with n = imm[3:0], shifts the window so that byte i becomes byte i+n (zero when i+n > 15) and sets outFrag to inFrag+n modulo 256. Move ops 0, 5, 6 and 7 are no-ops.
- R10: Every register, window byte and the fragment index that no slot writes passes from input to output unchanged.
- R11: When the ALU slot and a move load name the same destination register, the move slot (higher-numbered) result is kept.
- R12: A write with progWe high stores progWord at progAddr on the clock edge. Any later bundle whose pointer selects that entry executes the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progWe | input | 1 | Program store write enable |
| progAddr | input | ADDR_W | Program store write address |
| progWord | input | 64 | Instruction word to store |
| inValid | input | 1 | Incoming bundle valid |
| inRegs | input | 256 | Incoming general registers, register i at bits 32i+31:32i |
| inWindow | input | 128 | Incoming packet window, byte i at bits 8i+7:8i |
| inFrag | input | 8 | Incoming fragment index |
| inIp | input | 8 | Incoming instruction pointer |
| inFlag | input | 1 | Incoming condition flag |
| outValid | output | 1 | Outgoing bundle valid |
| outRegs | output | 256 | Outgoing general registers |
| outWindow | output | 128 | Outgoing packet window |
| outFrag | output | 8 | Outgoing fragment index |
| outIp | output | 8 | Outgoing instruction pointer |
| outFlag | output | 1 | Outgoing condition flag |

## Verification
The stage holds state only in its output bundle and its program store. A corrupted program entry or a bad slot decode therefore shows up on the very next clock, as a wrong register, byte, flag, fragment or pointer in the output bundle. A corrupted store also keeps showing up on every later bundle whose pointer selects that entry.

A fault in the hold logic for idle bundles shows up as output fields that change one cycle after inValid drops. Random words and bundles are compared field by field against a bench model. Directed words cover destination collisions, window wrap, the shift past byte 15 and pointer wrap.

// File: rtl/vliw_stage_pkg.sv
package vliw_stage_pkg;
  localparam int NUM_REGS   = 8;
  localparam int REG_W      = 32;
  localparam int REG_IDX_W  = $clog2(NUM_REGS);
  localparam int WIN_BYTES  = 16;
  localparam int WIN_IDX_W  = $clog2(WIN_BYTES);
  localparam int IP_W       = 8;
  localparam int FRAG_W     = 8;
  localparam int NUM_SLOTS  = 4;
  localparam int SLOT_W     = 16;
  localparam int INSTR_W    = NUM_SLOTS * SLOT_W;
  localparam int REGS_W     = NUM_REGS * REG_W;
  localparam int WIN_W      = WIN_BYTES * 8;

  typedef enum logic [2:0] {
    ALU_NOP, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR
  } aluOp_e;

  typedef enum logic [1:0] {
    BR_NONE, BR_ALWAYS, BR_IF_SET, BR_IF_CLR
  } brCond_e;

  typedef enum logic [2:0] {
    MOV_NOP, MOV_LDB, MOV_LDW, MOV_SETFRAG, MOV_ADVANCE
  } movOp_e;

  typedef struct packed {
    aluOp_e                aluOp;
    logic [REG_IDX_W-1:0]  aluRd;
    logic [REG_IDX_W-1:0]  aluRa;
    logic [REG_IDX_W-1:0]  aluRb;
    logic                  cmpEn;
    logic                  cmpLt;
    logic [REG_IDX_W-1:0]  cmpRa;
    logic [REG_IDX_W-1:0]  cmpRb;
    brCond_e               brCond;
    logic [IP_W-1:0]       brTarget;
    movOp_e                movOp;
    logic [REG_IDX_W-1:0]  movRd;
    logic [7:0]            movImm;
  } stageStrobes_t;
endpackage

// File: rtl/stage_ctrl.sv
module stage_ctrl
  import vliw_stage_pkg::*;
#(
  parameter int PROG_DEPTH = 16,
  parameter int ADDR_W     = $clog2(PROG_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                progWe,
  input  logic [ADDR_W-1:0]   progAddr,
  input  logic [INSTR_W-1:0]  progWord,
  input  logic [IP_W-1:0]     inIp,
  output stageStrobes_t       strb
);
  logic [INSTR_W-1:0] progMem [PROG_DEPTH];
  logic [ADDR_W-1:0]  fetchIdx;
  logic [INSTR_W-1:0] fetchWord;
  logic [SLOT_W-1:0]  slotWord [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (progWe) progMem[progAddr] <= progWord;
  end

  assign fetchIdx  = inIp[ADDR_W-1:0];
  assign fetchWord = progMem[fetchIdx];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    assign slotWord[g] = fetchWord[g*SLOT_W +: SLOT_W];
  end

  always_comb begin
    strb = '0;
    // slot 0: ALU
    unique case (slotWord[0][15:13])
      3'd1:    strb.aluOp = ALU_ADD;
      3'd2:    strb.aluOp = ALU_SUB;
      3'd3:    strb.aluOp = ALU_AND;
      3'd4:    strb.aluOp = ALU_OR;
      3'd5:    strb.aluOp = ALU_XOR;
      default: strb.aluOp = ALU_NOP;
    endcase
    strb.aluRd = slotWord[0][12:10];
    strb.aluRa = slotWord[0][9:7];
    strb.aluRb = slotWord[0][6:4];
    // slot 1: compare
    strb.cmpEn = (slotWord[1][15:13] == 3'd1) || (slotWord[1][15:13] == 3'd2);
    strb.cmpLt = (slotWord[1][15:13] == 3'd2);
    strb.cmpRa = slotWord[1][12:10];
    strb.cmpRb = slotWord[1][9:7];
    // slot 2: branch
    strb.brCond   = brCond_e'(slotWord[2][15:14]);
    strb.brTarget = slotWord[2][7:0];
    // slot 3: move
    unique case (slotWord[3][15:13])
      3'd1:    strb.movOp = MOV_LDB;
      3'd2:    strb.movOp = MOV_LDW;
      3'd3:    strb.movOp = MOV_SETFRAG;
      3'd4:    strb.movOp = MOV_ADVANCE;
      default: strb.movOp = MOV_NOP;
    endcase
    strb.movRd  = slotWord[3][12:10];
    strb.movImm = slotWord[3][7:0];
  end

  // R12: a freshly written entry is what the fetch path returns next cycle
  assert_prog_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    progWe |=> (fetchIdx != $past(progAddr)) || (fetchWord == $past(progWord)));
endmodule

// File: rtl/stage_dp.sv
module stage_dp
  import vliw_stage_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  stageStrobes_t      strb,
  input  logic               inValid,
  input  logic [REGS_W-1:0]  inRegs,
  input  logic [WIN_W-1:0]   inWindow,
  input  logic [FRAG_W-1:0]  inFrag,
  input  logic [IP_W-1:0]    inIp,
  input  logic               inFlag,
  output logic               outValid,
  output logic [REGS_W-1:0]  outRegs,
  output logic [WIN_W-1:0]   outWindow,
  output logic [FRAG_W-1:0]  outFrag,
  output logic [IP_W-1:0]    outIp,
  output logic               outFlag
);
  logic [REG_W-1:0]     rIn [NUM_REGS];
  logic [7:0]           winIn [WIN_BYTES];
  logic [REGS_W-1:0]    nextRegs;
  logic [WIN_W-1:0]     nextWin;
  logic [FRAG_W-1:0]    nextFrag;
  logic [IP_W-1:0]      nextIp;
  logic                 nextFlag;
  logic [REG_W-1:0]     aluA, aluB, aluRes;
  logic [REG_W-1:0]     cmpA, cmpB;
  logic [REG_W-1:0]     movVal;
  logic                 movWritesReg;
  logic [WIN_IDX_W-1:0] movOff;
  logic [WIN_IDX_W-1:0] shiftN;
  logic                 brTaken;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gUnpackRegs
    assign rIn[g] = inRegs[g*REG_W +: REG_W];
  end
  for (genvar g = 0; g < WIN_BYTES; g++) begin : gUnpackWin
    assign winIn[g] = inWindow[g*8 +: 8];
  end

  // ALU unit
  assign aluA = rIn[strb.aluRa];
  assign aluB = rIn[strb.aluRb];
  always_comb begin
    unique case (strb.aluOp)
      ALU_ADD: aluRes = aluA + aluB;
      ALU_SUB: aluRes = aluA - aluB;
      ALU_AND: aluRes = aluA & aluB;
      ALU_OR:  aluRes = aluA | aluB;
      ALU_XOR: aluRes = aluA ^ aluB;
      default: aluRes = '0;
    endcase
  end

  // compare unit
  assign cmpA     = rIn[strb.cmpRa];
  assign cmpB     = rIn[strb.cmpRb];
  assign nextFlag = !strb.cmpEn ? inFlag : (strb.cmpLt ? (cmpA < cmpB) : (cmpA == cmpB));

  // branch unit, tests the incoming flag
  always_comb begin
    unique case (strb.brCond)
      BR_ALWAYS: brTaken = 1'b1;
      BR_IF_SET: brTaken = inFlag;
      BR_IF_CLR: brTaken = !inFlag;
      default:   brTaken = 1'b0;
    endcase
  end
  assign nextIp = brTaken ? strb.brTarget : IP_W'(inIp + 1'b1);

  // move unit
  assign movOff       = strb.movImm[WIN_IDX_W-1:0];
  assign shiftN       = strb.movImm[WIN_IDX_W-1:0];
  assign movWritesReg = (strb.movOp == MOV_LDB) || (strb.movOp == MOV_LDW);
  always_comb begin
    if (strb.movOp == MOV_LDW)
      movVal = {winIn[WIN_IDX_W'(movOff + 3)], winIn[WIN_IDX_W'(movOff + 2)],
                winIn[WIN_IDX_W'(movOff + 1)], winIn[movOff]};
    else
      movVal = {{(REG_W-8){1'b0}}, winIn[movOff]};
  end

  always_comb begin
    unique case (strb.movOp)
      MOV_SETFRAG: nextFrag = strb.movImm;
      MOV_ADVANCE: nextFrag = FRAG_W'(inFrag + {{(FRAG_W-WIN_IDX_W){1'b0}}, shiftN});
      default:     nextFrag = inFrag;
    endcase
  end

  // register write merge: later slot overrides earlier one
  for (genvar g = 0; g < NUM_REGS; g++) begin : gMerge
    logic [REG_W-1:0] nxt;
    always_comb begin
      nxt = rIn[g];
      if (strb.aluOp != ALU_NOP && strb.aluRd == REG_IDX_W'(g)) nxt = aluRes;
      if (movWritesReg && strb.movRd == REG_IDX_W'(g))          nxt = movVal;
    end
    assign nextRegs[g*REG_W +: REG_W] = nxt;
  end

  // window shift
  for (genvar g = 0; g < WIN_BYTES; g++) begin : gShift
    logic [WIN_IDX_W:0] src;
    assign src = (WIN_IDX_W+1)'(g) + {1'b0, shiftN};
    assign nextWin[g*8 +: 8] = (strb.movOp != MOV_ADVANCE) ? winIn[g] :
                               (src[WIN_IDX_W] ? 8'h00 : winIn[src[WIN_IDX_W-1:0]]);
  end

  // bundle registers handed to the next stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outRegs   <= '0;
      outWindow <= '0;
      outFrag   <= '0;
      outIp     <= '0;
      outFlag   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outRegs   <= nextRegs;
        outWindow <= nextWin;
        outFrag   <= nextFrag;
        outIp     <= nextIp;
        outFlag   <= nextFlag;
      end
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outRegs) && $stable(outWindow) && $stable(outFrag)
                 && $stable(outIp) && $stable(outFlag));
  assert_flag_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !strb.cmpEn) |=> outFlag == $past(inFlag));
  assert_ip_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strb.brCond == BR_NONE) |=> outIp == IP_W'($past(inIp) + 1'b1));
  assert_frag_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strb.movOp == MOV_SETFRAG) |=> outFrag == $past(strb.movImm));
endmodule

// File: rtl/vliw_flow_stage.sv
module vliw_flow_stage
  import vliw_stage_pkg::*;
#(
  parameter int PROG_DEPTH = 16,
  parameter int ADDR_W     = $clog2(PROG_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                progWe,
  input  logic [ADDR_W-1:0]   progAddr,
  input  logic [INSTR_W-1:0]  progWord,
  input  logic                inValid,
  input  logic [REGS_W-1:0]   inRegs,
  input  logic [WIN_W-1:0]    inWindow,
  input  logic [FRAG_W-1:0]   inFrag,
  input  logic [IP_W-1:0]     inIp,
  input  logic                inFlag,
  output logic                outValid,
  output logic [REGS_W-1:0]   outRegs,
  output logic [WIN_W-1:0]    outWindow,
  output logic [FRAG_W-1:0]   outFrag,
  output logic [IP_W-1:0]     outIp,
  output logic                outFlag
);
  stageStrobes_t strb;

  stage_ctrl #(.PROG_DEPTH(PROG_DEPTH), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .progWe(progWe), .progAddr(progAddr),
    .progWord(progWord), .inIp(inIp), .strb(strb)
  );

  stage_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .inValid(inValid),
    .inRegs(inRegs), .inWindow(inWindow), .inFrag(inFrag), .inIp(inIp),
    .inFlag(inFlag), .outValid(outValid), .outRegs(outRegs),
    .outWindow(outWindow), .outFrag(outFrag), .outIp(outIp), .outFlag(outFlag)
  );
endmodule

// File: tb/tb_vliw_flow_stage.sv
module tb_vliw_flow_stage;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic clk = 1'b0;
  logic rstN;
  logic progWe;
  logic [3:0] progAddr;
  logic [63:0] progWord;
  logic inValid;
  logic [255:0] inRegs;
  logic [127:0] inWindow;
  logic [7:0] inFrag, inIp;
  logic inFlag;
  logic outValid;
  logic [255:0] outRegs;
  logic [127:0] outWindow;
  logic [7:0] outFrag, outIp;
  logic outFlag;

  vliw_flow_stage #(.PROG_DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .progWe(progWe), .progAddr(progAddr), .progWord(progWord),
    .inValid(inValid), .inRegs(inRegs), .inWindow(inWindow), .inFrag(inFrag),
    .inIp(inIp), .inFlag(inFlag), .outValid(outValid), .outRegs(outRegs),
    .outWindow(outWindow), .outFrag(outFrag), .outIp(outIp), .outFlag(outFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [63:0] shadow [DEPTH];
  logic expValid;
  logic [255:0] expRegs;
  logic [127:0] expWin;
  logic [7:0] expFrag, expIp;
  logic expFlag;

  function automatic logic [31:0] getReg(logic [255:0] r, logic [2:0] i);
    return r[i*32 +: 32];
  endfunction

  function automatic logic [7:0] getByte(logic [127:0] w, logic [3:0] i);
    return w[i*8 +: 8];
  endfunction

  task automatic model(input logic [63:0] w, input logic [255:0] r, input logic [127:0] win,
                       input logic [7:0] fr, input logic [7:0] ip, input logic fl,
                       output logic [255:0] oR, output logic [127:0] oW,
                       output logic [7:0] oF, output logic [7:0] oI, output logic oL);
    logic [15:0] s0, s1, s2, s3;
    logic [31:0] a, b, res;
    logic [3:0] off;
    logic taken;
    s0 = w[15:0]; s1 = w[31:16]; s2 = w[47:32]; s3 = w[63:48];
    oR = r; oW = win; oF = fr; oL = fl;
    // R5 ALU
    a = getReg(r, s0[9:7]); b = getReg(r, s0[6:4]);
    case (s0[15:13])
      3'd1: res = a + b;
      3'd2: res = a - b;
      3'd3: res = a & b;
      3'd4: res = a | b;
      3'd5: res = a ^ b;
      default: res = '0;
    endcase
    if (s0[15:13] >= 3'd1 && s0[15:13] <= 3'd5) oR[s0[12:10]*32 +: 32] = res;
    // R6 compare
    a = getReg(r, s1[12:10]); b = getReg(r, s1[9:7]);
    if (s1[15:13] == 3'd1) oL = (a == b);
    if (s1[15:13] == 3'd2) oL = (a < b);
    // R7 branch on incoming flag
    taken = (s2[15:14] == 2'd1) || (s2[15:14] == 2'd2 && fl) || (s2[15:14] == 2'd3 && !fl);
    oI = taken ? s2[7:0] : 8'(ip + 8'd1);
    // R8/R9 move, later slot wins (R11)
    off = s3[3:0];
    case (s3[15:13])
      3'd1: oR[s3[12:10]*32 +: 32] = {24'd0, getByte(win, off)};
      3'd2: oR[s3[12:10]*32 +: 32] = {getByte(win, 4'(off+3)), getByte(win, 4'(off+2)),
                                      getByte(win, 4'(off+1)), getByte(win, off)};
      3'd3: oF = s3[7:0];
      3'd4: begin
        oF = 8'(fr + {4'd0, off});
        for (int i = 0; i < 16; i++)
          oW[i*8 +: 8] = (i + off > 15) ? 8'h00 : getByte(win, 4'(i + off));
      end
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic loadWord(input int idx, input logic [63:0] w);
    progWe = 1'b1; progAddr = 4'(idx); progWord = w;
    shadow[idx] = w;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic apply(input string tag, input logic v, input logic [255:0] r,
                       input logic [127:0] win, input logic [7:0] fr,
                       input logic [7:0] ip, input logic fl);
    inValid = v; inRegs = r; inWindow = win; inFrag = fr; inIp = ip; inFlag = fl;
    if (v) model(shadow[ip % DEPTH], r, win, fr, ip, fl, expRegs, expWin, expFrag, expIp, expFlag);
    expValid = v;
    @(negedge clk);
    check({tag, " R2 valid"}, {255'd0, outValid}, {255'd0, expValid});
    if (v) begin
      check({tag, " R5 R8 R10 R11 regs"}, outRegs, expRegs);
      check({tag, " R9 R10 window"}, {128'd0, outWindow}, {128'd0, expWin});
      check({tag, " R9 R10 frag"}, {248'd0, outFrag}, {248'd0, expFrag});
      check({tag, " R4 R7 ip"}, {248'd0, outIp}, {248'd0, expIp});
      check({tag, " R6 flag"}, {255'd0, outFlag}, {255'd0, expFlag});
    end else begin
      check({tag, " R3 hold regs"}, outRegs, expRegs);
      check({tag, " R3 hold others"}, {111'd0, outWindow, outFrag, outIp, outFlag},
            {111'd0, expWin, expFrag, expIp, expFlag});
    end
  endtask

  function automatic logic [255:0] rndRegs();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [127:0] rndWin();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
      $finish;
    end
  end

  initial begin
    logic [255:0] r;
    logic [127:0] w;
    void'($urandom(32'h1357_9BDF));
    rstN = 1'b0; progWe = 1'b0; progAddr = '0; progWord = '0;
    inValid = 1'b0; inRegs = '0; inWindow = '0; inFrag = '0; inIp = '0; inFlag = 1'b0;
    expValid = 1'b0; expRegs = '0; expWin = '0; expFrag = '0; expIp = '0; expFlag = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {110'd0, outValid, outRegs[127:0], outWindow[0 +: 8], outFrag, outIp, outFlag,
          outRegs[255:128] | {outWindow, 8'd0}}, 256'd0);
    rstN = 1'b1;
    @(negedge clk);

    // program: directed entries 0..5, random elsewhere
    loadWord(0, {3'd1, 3'd2, 2'd0, 8'd5,  16'd0, 16'd0, 3'd1, 3'd2, 3'd0, 3'd1, 4'd0});
    loadWord(1, {16'd0, 2'd2, 6'd0, 8'h40, 3'd1, 3'd4, 3'd4, 7'd0, 3'd2, 3'd3, 3'd0, 3'd1, 4'd0});
    loadWord(2, {3'd4, 3'd0, 2'd0, 8'd3, 16'd0, 3'd2, 3'd0, 3'd1, 7'd0, 3'd5, 3'd6, 3'd6, 3'd7, 4'd0});
    loadWord(3, {3'd2, 3'd7, 2'd0, 8'd14, 2'd1, 6'd0, 8'h22, 16'd0, 16'd0});
    loadWord(4, {3'd3, 3'd0, 2'd0, 8'h99, 2'd3, 6'd0, 8'h10, 16'd0, 3'd6, 13'h1fff});
    loadWord(5, 64'd0);
    for (int i = 6; i < DEPTH; i++) loadWord(i, {$urandom, $urandom});

    r = rndRegs(); w = rndWin();
    apply("R11 collision", 1'b1, r, w, 8'd7, 8'd0, 1'b0);
    r[4*32 +: 32] = 32'hCAFE; r[3*32 +: 32] = 32'h1;
    apply("R6 eq + R7 not-taken", 1'b1, r, w, 8'd1, 8'd1, 1'b0);
    apply("R7 taken on flag", 1'b1, r, w, 8'd1, 8'd1, 1'b1);
    r[0 +: 32] = 32'd5; r[32 +: 32] = 32'hFFFF_FFFF;
    apply("R9 advance + R6 lt", 1'b1, r, w, 8'd250, 8'd2, 1'b0);
    apply("R8 word wrap", 1'b1, rndRegs(), rndWin(), 8'd3, 8'd3, 1'b1);
    apply("R9 setfrag", 1'b1, rndRegs(), rndWin(), 8'd4, 8'd4, 1'b0);
    apply("R10 all nop", 1'b1, rndRegs(), rndWin(), 8'd77, 8'd5, 1'b1);
    apply("R3 idle", 1'b0, rndRegs(), rndWin(), 8'd9, 8'd5, 1'b0);
    apply("R4 R7 ip wrap", 1'b1, rndRegs(), rndWin(), 8'd1, 8'd255, 1'b0);

    // R12 rewrite entry 5 and execute it
    loadWord(5, {16'd0, 16'd0, 16'd0, 3'd5, 3'd1, 3'd1, 3'd1, 4'd0});
    apply("R12 rewritten", 1'b1, rndRegs(), rndWin(), 8'd0, 8'd5, 1'b0);

    for (int n = 0; n < 400; n++) begin
      logic v;
      v = ($urandom % 100) < 85;
      r = rndRegs();
      if ($urandom % 4 == 0) r[32 +: 32] = r[0 +: 32];
      apply("random", v, r, rndWin(), 8'($urandom), 8'($urandom), 1'($urandom));
      if (n % 100 == 50) loadWord(int'($urandom % DEPTH), {$urandom, $urandom});
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule